// File: doc/BRIEF.md
# Small-Page NAND Command Front End

This block sits on the device side of a small-page NAND flash bus. It watches the multiplexed 8-bit I/O lines together with chip enable, write enable and the two latch-select lines. It sorts every accepted write into a command byte, an address byte or a data byte. It follows the multi-cycle command sequences for read, program, erase and copy-back. It collects the column and row address bytes and keeps the page-register area pointer. When a sequence completes, it issues a one-clock operation strobe to the array back end, with the resolved column and row.

The back end reports through `busy` whether an array operation is in progress. While `busy` is high, only the status commands and reset are honoured. A command that is illegal, or that arrives out of its context, raises a one-clock error flag. The decoder then returns to idle without issuing anything.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus byte is taken only on a rising edge of `we_n` while `ce_n` is low. `cle`=1 with `ale`=0 makes it a command, and `ale`=1 with `cle`=0 makes it an address. An edge with `ce_n` high has no effect.
- R2: Data cycles (both latch lines low) have no effect on the outputs. An address byte outside an address phase, or beyond the bytes a sequence needs, also has no effect.
- R3: Codes 00h, 01h and 50h start a read. The four address bytes follow in the order column, row bits 7:0, row bits 15:8, row bits 17:16. The fourth address byte issues a read (`op_kind`=0), and bits 7:2 of that byte are ignored.
- R4: `area_ptr` is 0 after 00h, 1 after 01h and 2 after 50h. The column `op_col` is the column byte for area 0 and 256 plus the column byte for area 1. For area 2 it is 512 plus the low 4 bits of the column byte, which gives 512..527. After an operation issued from area 1, the pointer returns to 0. Area 2 persists.
- R5: 80h, four address bytes, any data bytes, then 10h issues a program (`op_kind`=1) with `op_final`=1. Ending with 11h issues it with `op_final`=0. A confirm code before the fourth address byte raises `cmd_err`.
- R6: 60h with three row bytes (no column byte) arms an erase. D0h then issues an erase (`op_kind`=2, `op_final`=1, `op_col`=0). Another 60h instead issues an erase with `op_final`=0 for the armed block and starts a new row collection.
- R7: 8Ah with four address bytes followed by 10h or 11h issues copy-back (`op_kind`=3) with `op_final` 1 or 0. 03h starts a read like 00h, using area 0.
- R8: 70h, 71h, 90h and FFh issue status (4), plane status (5), ID (6) and reset (7) on their command cycle. Reset also aborts any sequence and sets `area_ptr` to 0.
- R9: While `busy` is high, only 70h, 71h and FFh are accepted. Any other command raises `cmd_err`. Address bytes are ignored.
- R10: A code outside the defined set, or a confirm with no matching sequence, raises `cmd_err` for one clock, issues no operation and returns to idle.
- R11: `op_valid` and `cmd_err` are single-clock pulses, registered one clock after the qualifying bus edge, and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, byte taken on its rising edge |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| io | input | 8 | Multiplexed bus byte |
| busy | input | 1 | Back end is executing an array operation |
| op_valid | output | 1 | One-clock operation strobe |
| op_kind | output | 3 | Operation code (0 read .. 7 reset) |
| op_final | output | 1 | 1 for a true confirm, 0 for a dummy-plane confirm |
| op_col | output | 10 | Resolved page column 0..527 |
| op_row | output | 18 | Collected row address |
| area_ptr | output | 2 | Current page-register area pointer |
| cmd_err | output | 1 | One-clock illegal or refused command flag |

## Verification
The bench builds the block with its defaults: an 8-bit column, a 4-bit spare offset and an 18-bit row. With these values the last row cycle carries only two live bits, so the masking of its upper bits can be checked, and the spare window ends exactly at column 527. Each width of the resolved column therefore meets a real boundary: 255/256 between halves and 512..527 for the spare area.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_COPY   = 3'd3,
        OP_STAT   = 3'd4,
        OP_MSTAT  = 3'd5,
        OP_ID     = 3'd6,
        OP_RESET  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        AREA_LO    = 2'd0,
        AREA_HI    = 2'd1,
        AREA_SPARE = 2'd2
    } area_e;

    typedef enum logic [3:0] {
        CMD_RD_LO, CMD_RD_HI, CMD_RD_SP, CMD_RD_CB,
        CMD_PROG, CMD_COPY, CMD_ERASE,
        CMD_CONF_T, CMD_CONF_D, CMD_CONF_E,
        CMD_STAT, CMD_MSTAT, CMD_ID, CMD_RST, CMD_BAD
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RADDR, ST_PADDR, ST_PDATA,
        ST_CADDR, ST_CWAIT, ST_EADDR, ST_EWAIT
    } st_e;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic cle,
    input  logic ale,
    output logic cyc_cmd,
    output logic cyc_addr
);
    typedef struct packed {
        logic we_prev;
    } smp_t;

    smp_t s_d, s_q;
    logic edge_ok;

    // Data cycles (both latch lines low) carry no control meaning here.
    always_comb begin
        s_d         = s_q;
        s_d.we_prev = we_n;
        edge_ok     = !ce_n && we_n && !s_q.we_prev;
        cyc_cmd     = edge_ok && cle && !ale;
        cyc_addr    = edge_ok && ale && !cle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{we_prev: 1'b1};
        else        s_q <= s_d;
    end

    AST_CYCLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cmd || cyc_addr) |=> !(cyc_cmd || cyc_addr)); // R1

endmodule

// File: rtl/nand_cmd_lookup.sv
module nand_cmd_lookup
    import nand_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cls
);
    always_comb begin
        case (code)
            8'h00:   cls = CMD_RD_LO;
            8'h01:   cls = CMD_RD_HI;
            8'h50:   cls = CMD_RD_SP;
            8'h03:   cls = CMD_RD_CB;
            8'h80:   cls = CMD_PROG;
            8'h8A:   cls = CMD_COPY;
            8'h60:   cls = CMD_ERASE;
            8'h10:   cls = CMD_CONF_T;
            8'h11:   cls = CMD_CONF_D;
            8'hD0:   cls = CMD_CONF_E;
            8'h70:   cls = CMD_STAT;
            8'h71:   cls = CMD_MSTAT;
            8'h90:   cls = CMD_ID;
            8'hFF:   cls = CMD_RST;
            default: cls = CMD_BAD;
        endcase
    end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_cmd_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int SPARE_W = 4,
    parameter int ROW_W   = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic                 cle,
    input  logic                 ale,
    input  logic [7:0]           io,
    input  logic                 busy,
    output logic                 op_valid,
    output logic [2:0]           op_kind,
    output logic                 op_final,
    output logic [COL_W+1:0]     op_col,
    output logic [ROW_W-1:0]     op_row,
    output logic [1:0]           area_ptr,
    output logic                 cmd_err
);
    localparam int CW         = COL_W + 2;
    localparam int HALF       = 1 << COL_W;
    localparam int SPARE_BASE = 2 * HALF;
    localparam int SPARE_LAST = SPARE_BASE + (1 << SPARE_W) - 1;

    typedef struct packed {
        st_e              st;
        logic [1:0]       acnt;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        area_e            area;
        logic             op_valid;
        op_e              op_kind;
        logic             op_final;
        logic [CW-1:0]    op_col;
        logic [ROW_W-1:0] op_row;
        logic             err;
    } fr_t;

    fr_t  f_d, f_q;
    logic cyc_cmd, cyc_addr;
    cmd_e cls;
    logic [ROW_W-1:0] row_n;

    nand_bus_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .cle(cle), .ale(ale), .cyc_cmd(cyc_cmd), .cyc_addr(cyc_addr)
    );

    nand_cmd_lookup u_lut (.code(io), .cls(cls));

    function automatic logic [CW-1:0] eff_col(area_e a, logic [COL_W-1:0] c);
        logic [CW-1:0] r;
        r = '0;
        case (a)
            AREA_HI:    r = {2'b01, c};
            AREA_SPARE: r = CW'(SPARE_BASE) + CW'(c[SPARE_W-1:0]);
            default:    r = {2'b00, c};
        endcase
        return r;
    endfunction

    function automatic logic [ROW_W-1:0] put_row(logic [ROW_W-1:0] r,
                                                 int slot, logic [7:0] b);
        logic [ROW_W-1:0] t;
        t = r;
        for (int i = 0; i < ROW_W; i++)
            if (i / 8 == slot) t[i] = b[i % 8];
        return t;
    endfunction

    always_comb begin
        f_d          = f_q;
        f_d.op_valid = 1'b0;
        f_d.err      = 1'b0;
        row_n        = f_q.row;
        if (cyc_cmd) begin
            if (busy && !(cls inside {CMD_STAT, CMD_MSTAT, CMD_RST})) begin
                f_d.err = 1'b1;
                f_d.st  = ST_IDLE;
            end else begin
                case (cls)
                    CMD_RD_LO, CMD_RD_CB: begin
                        f_d.area = AREA_LO; f_d.st = ST_RADDR; f_d.acnt = '0;
                    end
                    CMD_RD_HI: begin
                        f_d.area = AREA_HI; f_d.st = ST_RADDR; f_d.acnt = '0;
                    end
                    CMD_RD_SP: begin
                        f_d.area = AREA_SPARE; f_d.st = ST_RADDR; f_d.acnt = '0;
                    end
                    CMD_PROG: begin f_d.st = ST_PADDR; f_d.acnt = '0; end
                    CMD_COPY: begin f_d.st = ST_CADDR; f_d.acnt = '0; end
                    CMD_ERASE: begin
                        if (f_q.st == ST_EWAIT) begin
                            f_d.op_valid = 1'b1; f_d.op_kind = OP_ERASE;
                            f_d.op_final = 1'b0; f_d.op_col = '0;
                            f_d.op_row = f_q.row;
                        end
                        f_d.st = ST_EADDR; f_d.acnt = '0;
                    end
                    CMD_CONF_T, CMD_CONF_D: begin
                        if (f_q.st == ST_PDATA || f_q.st == ST_CWAIT) begin
                            f_d.op_valid = 1'b1;
                            f_d.op_kind  = (f_q.st == ST_PDATA) ? OP_PROG : OP_COPY;
                            f_d.op_final = (cls == CMD_CONF_T);
                            f_d.op_col   = eff_col(f_q.area, f_q.col);
                            f_d.op_row   = f_q.row;
                            if (f_q.area == AREA_HI) f_d.area = AREA_LO;
                        end else begin
                            f_d.err = 1'b1;
                        end
                        f_d.st = ST_IDLE;
                    end
                    CMD_CONF_E: begin
                        if (f_q.st == ST_EWAIT) begin
                            f_d.op_valid = 1'b1; f_d.op_kind = OP_ERASE;
                            f_d.op_final = 1'b1; f_d.op_col = '0;
                            f_d.op_row = f_q.row;
                        end else begin
                            f_d.err = 1'b1;
                        end
                        f_d.st = ST_IDLE;
                    end
                    CMD_STAT: begin f_d.op_valid = 1'b1; f_d.op_kind = OP_STAT; end
                    CMD_MSTAT: begin f_d.op_valid = 1'b1; f_d.op_kind = OP_MSTAT; end
                    CMD_ID: begin
                        f_d.op_valid = 1'b1; f_d.op_kind = OP_ID; f_d.st = ST_IDLE;
                    end
                    CMD_RST: begin
                        f_d.op_valid = 1'b1; f_d.op_kind = OP_RESET;
                        f_d.st = ST_IDLE; f_d.area = AREA_LO;
                    end
                    default: begin f_d.err = 1'b1; f_d.st = ST_IDLE; end
                endcase
            end
        end else if (cyc_addr && !busy) begin
            case (f_q.st)
                ST_RADDR, ST_PADDR, ST_CADDR: begin
                    if (f_q.acnt == 2'd0) f_d.col = io;
                    else row_n = put_row(f_q.row, int'(f_q.acnt) - 1, io);
                    f_d.row = row_n;
                    if (f_q.acnt == 2'd3) begin
                        if (f_q.st == ST_RADDR) begin
                            f_d.op_valid = 1'b1; f_d.op_kind = OP_READ;
                            f_d.op_final = 1'b1;
                            f_d.op_col   = eff_col(f_q.area, f_q.col);
                            f_d.op_row   = row_n;
                            if (f_q.area == AREA_HI) f_d.area = AREA_LO;
                            f_d.st = ST_IDLE;
                        end else begin
                            f_d.st = (f_q.st == ST_PADDR) ? ST_PDATA : ST_CWAIT;
                        end
                    end else begin
                        f_d.acnt = f_q.acnt + 2'd1;
                    end
                end
                ST_EADDR: begin
                    row_n   = put_row(f_q.row, int'(f_q.acnt), io);
                    f_d.row = row_n;
                    if (f_q.acnt == 2'd2) f_d.st = ST_EWAIT;
                    else                  f_d.acnt = f_q.acnt + 2'd1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign op_valid = f_q.op_valid;
    assign op_kind  = f_q.op_kind;
    assign op_final = f_q.op_final;
    assign op_col   = f_q.op_col;
    assign op_row   = f_q.op_row;
    assign area_ptr = f_q.area;
    assign cmd_err  = f_q.err;

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid); // R11
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !op_valid); // R10
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(busy)) |-> (op_kind inside {3'd4, 3'd5, 3'd7})); // R9
    AST_SPARE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd0 && area_ptr == 2'd2)
        |-> (int'(op_col) >= SPARE_BASE && int'(op_col) <= SPARE_LAST)); // R4
    AST_HI_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd0 && int'(op_col) >= HALF
         && int'(op_col) < SPARE_BASE) |-> area_ptr == 2'd0); // R4
    AST_ERASE_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd2) |-> op_col == '0); // R6

endmodule

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
    logic [7:0] io = '0;
    logic op_valid, op_final, cmd_err;
    logic [2:0] op_kind;
    logic [9:0] op_col;
    logic [17:0] op_row;
    logic [1:0] area_ptr;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic s_v, s_f, s_e;
    logic [2:0] s_k;
    logic [9:0] s_c;
    logic [17:0] s_r;
    logic [1:0] s_a;

    always #4 clk = ~clk;

    nand_cmd_front uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle),
        .ale(ale), .io(io), .busy(busy), .op_valid(op_valid),
        .op_kind(op_kind), .op_final(op_final), .op_col(op_col),
        .op_row(op_row), .area_ptr(area_ptr), .cmd_err(cmd_err)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // kind: 0 command, 1 address, 2 data
    task automatic wr(int kind, logic [7:0] b, logic ce = 1'b0);
        @(negedge clk);
        ce_n = ce; cle = (kind == 0); ale = (kind == 1); io = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        s_v = op_valid; s_k = op_kind; s_f = op_final; s_c = op_col;
        s_r = op_row; s_e = cmd_err; s_a = area_ptr;
        ce_n = 1'b1;
    endtask

    task automatic addr4(logic [7:0] c, logic [7:0] r0, logic [7:0] r1, logic [7:0] r2);
        wr(1, c); wr(1, r0); wr(1, r1); wr(1, r2);
    endtask

    task automatic chk_op(string tag, int k, int f, int c, int r);
        chk(s_v == 1'b1, tag, "op_valid", s_v, 1);
        chk(s_e == 1'b0, tag, "cmd_err", s_e, 0);
        chk(s_k == k, tag, "op_kind", s_k, k);
        if (f >= 0) chk(s_f == f, tag, "op_final", s_f, f);
        if (c >= 0) chk(s_c == c, tag, "op_col", s_c, c);
        if (r >= 0) chk(s_r == r, tag, "op_row", s_r, r);
    endtask

    task automatic chk_quiet(string tag);
        chk(s_v == 1'b0, tag, "op_valid quiet", s_v, 0);
        chk(s_e == 1'b0, tag, "cmd_err quiet", s_e, 0);
    endtask

    task automatic chk_err(string tag);
        chk(s_e == 1'b1, tag, "cmd_err", s_e, 1);
        chk(s_v == 1'b0, tag, "op_valid with err", s_v, 0);
    endtask

    task automatic t_reset;
        chk(op_valid == 0 && cmd_err == 0, "R11", "reset strobes", {op_valid, cmd_err}, 0);
        chk(area_ptr == 0, "R4", "reset area", area_ptr, 0);
    endtask

    task automatic t_read_basic; // R3, R1
        wr(0, 8'h00); chk_quiet("R3");
        addr4(8'h5A, 8'h34, 8'h12, 8'hFF);
        chk_op("R3", 0, -1, 8'h5A, 18'h31234);
        @(negedge clk);
        chk(op_valid == 0, "R11", "strobe width", op_valid, 0);
        wr(0, 8'h70, 1'b1); chk_quiet("R1");
    endtask

    task automatic t_areas; // R4
        wr(0, 8'h01);
        chk(s_a == 1, "R4", "ptr after 01h", s_a, 1);
        addr4(8'h10, 8'h01, 8'h00, 8'h00);
        chk_op("R4", 0, -1, 272, 1);
        chk(s_a == 0, "R4", "ptr falls back", s_a, 0);
        wr(0, 8'h50);
        addr4(8'h2B, 8'h00, 8'h00, 8'h00);
        chk_op("R4", 0, -1, 523, 0);
        chk(s_a == 2, "R4", "spare persists", s_a, 2);
        wr(0, 8'h00);
        addr4(8'hFF, 8'h00, 8'h00, 8'h00);
        chk_op("R4", 0, -1, 255, 0);
    endtask

    task automatic t_program; // R5, R2
        wr(0, 8'h80);
        addr4(8'h07, 8'h11, 8'h22, 8'h01);
        chk_quiet("R5");
        wr(2, 8'hAB); chk_quiet("R2");
        wr(1, 8'h99); chk_quiet("R2");
        wr(0, 8'h10);
        chk_op("R5", 1, 1, 7, 18'h12211);
        wr(0, 8'h80);
        addr4(8'h03, 8'h04, 8'h00, 8'h00);
        wr(0, 8'h11);
        chk_op("R5", 1, 0, 3, 4);
        wr(0, 8'h80); wr(1, 8'h01); wr(1, 8'h02);
        wr(0, 8'h10); chk_err("R5");
    endtask

    task automatic t_erase; // R6
        wr(0, 8'h60);
        wr(1, 8'h01); wr(1, 8'h02); wr(1, 8'h00);
        chk_quiet("R6");
        wr(0, 8'h60);
        chk_op("R6", 2, 0, 0, 18'h00201);
        wr(1, 8'h03); wr(1, 8'h00); wr(1, 8'h02);
        wr(0, 8'hD0);
        chk_op("R6", 2, 1, 0, 18'h20003);
    endtask

    task automatic t_copy; // R7
        wr(0, 8'h00);
        addr4(8'h00, 8'h05, 8'h00, 8'h00);
        chk_op("R7", 0, -1, 0, 5);
        wr(0, 8'h8A);
        addr4(8'h00, 8'h06, 8'h00, 8'h00);
        wr(0, 8'h10);
        chk_op("R7", 3, 1, 0, 6);
        wr(0, 8'h01);
        wr(0, 8'h03);
        chk(s_a == 0, "R7", "03h area", s_a, 0);
        addr4(8'h09, 8'h07, 8'h00, 8'h00);
        chk_op("R7", 0, -1, 9, 7);
        wr(0, 8'h8A);
        addr4(8'h00, 8'h08, 8'h00, 8'h00);
        wr(0, 8'h11);
        chk_op("R7", 3, 0, 0, 8);
    endtask

    task automatic t_immediate; // R8
        wr(0, 8'h70); chk_op("R8", 4, -1, -1, -1);
        wr(0, 8'h71); chk_op("R8", 5, -1, -1, -1);
        wr(0, 8'h90); chk_op("R8", 6, -1, -1, -1);
        wr(0, 8'h50); wr(0, 8'h80); wr(1, 8'h01);
        wr(0, 8'hFF); chk_op("R8", 7, -1, -1, -1);
        chk(s_a == 0, "R8", "reset area", s_a, 0);
        wr(1, 8'h01); wr(1, 8'h01); wr(1, 8'h01); chk_quiet("R8");
        wr(0, 8'h10); chk_err("R8");
    endtask

    task automatic t_busy; // R9
        busy = 1'b1;
        wr(0, 8'h00); chk_err("R9");
        wr(0, 8'h60); chk_err("R9");
        wr(0, 8'h70); chk_op("R9", 4, -1, -1, -1);
        wr(0, 8'hFF); chk_op("R9", 7, -1, -1, -1);
        busy = 1'b0;
        wr(0, 8'h00); wr(1, 8'h22);
        busy = 1'b1; wr(1, 8'hEE); chk_quiet("R9");
        busy = 1'b0;
        wr(1, 8'h0A); wr(1, 8'h0B); wr(1, 8'h00);
        chk_op("R9", 0, -1, 8'h22, 18'h00B0A);
    endtask

    task automatic t_illegal; // R10
        wr(0, 8'h42); chk_err("R10");
        @(negedge clk);
        chk(cmd_err == 0, "R10", "err width", cmd_err, 0);
        wr(0, 8'hD0); chk_err("R10");
        wr(0, 8'h60); wr(1, 8'h01); wr(1, 8'h00); wr(1, 8'h00);
        wr(0, 8'hC3); chk_err("R10");
        wr(0, 8'hD0); chk_err("R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_areas();
        t_program();
        t_erase();
        t_copy();
        t_immediate();
        t_busy();
        t_illegal();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule